// File: doc/BRIEF.md
# Big-Endian Byte/Word Load-Store Alignment Unit

This unit sits between a processor datapath and a data memory that is one word (four bytes) wide and answers reads one clock after the request. On each request it adds a sign-extended 16-bit byte offset to a base register value to form a byte address, and sends the matching word address to memory. Four operations are supported: word load, byte load, word store and byte store. Bytes are numbered big-endian, so byte offset 0 within a word is its most significant byte.

Stores produce per-lane write enables. A word store enables all four lanes. A byte store copies the low source byte onto every lane and enables only the one addressed lane. Word accesses whose byte address is not a multiple of four raise an alignment fault and are dropped. Loads return in the following cycle. A byte load picks the addressed lane using the lane index captured at request time and sign-extends it to 32 bits.

A two-state controller tracks outstanding loads. The state IDLE means no load result is due. The state LOAD_RESP means a load result is presented this cycle. The transition IDLE→LOAD_RESP is taken on an accepted load. LOAD_RESP→LOAD_RESP is taken on a back-to-back accepted load. Either state returns to IDLE when no load is accepted.

Top module: `lsu_align`

## Requirements
- R1: The byte address is req_base plus req_offset sign-extended to 32 bits, wrapping modulo 2^32. mem_addr shows that address with bits 1:0 cleared, in the same cycle as the request.
- R2: A word load (req_op 2'b00) or word store (req_op 2'b10) whose byte address has nonzero bits 1:0 raises align_fault in that cycle. mem_rd and all mem_wen bits stay low, and no ld_valid follows.
- R3: An aligned word store drives mem_wen = 4'b1111 and mem_wdata = req_src.
- R4: A byte store (req_op 2'b11) never faults. It drives req_src[7:0] on all four lanes of mem_wdata and sets exactly one mem_wen bit, bit (3 − k) for byte offset k. Offset 0 enables mem_wen[3], which covers data bits 31:24.
- R5: A byte store changes only the addressed byte of the memory word; the other three bytes read back unchanged.
- R6: An aligned word load asserts mem_rd in the request cycle. In the next cycle it raises ld_valid with ld_data equal to mem_rdata.
- R7: A byte load (req_op 2'b01) at byte offset k returns mem_rdata bits [31−8k : 24−8k] in ld_data[7:0] in the next cycle, with bit 7 copied into bits 31:8.
- R8: The lane index is captured at request time, so back-to-back byte loads at different offsets each return their own byte.
- R9: After reset, and in any cycle without req_valid, ld_valid, align_fault, mem_rd and mem_wen are all low. mem_rd and mem_wen are never active together.
- R10: ld_valid is high only in the cycle right after a cycle in which mem_rd was high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request present this cycle |
| req_op | input | 2 | 00 word load, 01 byte load, 10 word store, 11 byte store |
| req_base | input | 32 | Base register contents |
| req_offset | input | 16 | Signed byte offset |
| req_src | input | 32 | Store source register |
| mem_addr | output | 32 | Word-aligned memory address |
| mem_rd | output | 1 | Memory read strobe |
| mem_wen | output | 4 | Lane write enables, bit 3 = bits 31:24 |
| mem_wdata | output | 32 | Memory write data |
| mem_rdata | input | 32 | Memory read data, one cycle after mem_rd |
| align_fault | output | 1 | Misaligned word access rejected |
| ld_valid | output | 1 | Load result valid |
| ld_data | output | 32 | Aligned, extended load result |

## Verification
The assertions assume that req_op is only examined while req_valid is high. They also assume the memory returns mem_rdata exactly one cycle after mem_rd, with no stall. The bench issues at most one request per cycle and models a memory with a fixed one-cycle read. For each random access it picks the byte address first and derives the base from the chosen offset, so every address, including wrapped negative-offset ones, lands inside the modelled 64-byte window. Misaligned word accesses are deliberately mixed in, and the bench later reads those words back to confirm they were not written.

// File: rtl/lsu_align_pkg.sv
package lsu_align_pkg;

    typedef enum logic [1:0] {
        OP_LW = 2'b00,
        OP_LB = 2'b01,
        OP_SW = 2'b10,
        OP_SB = 2'b11
    } lsu_op_e;

    typedef enum logic {
        ST_IDLE      = 1'b0,
        ST_LOAD_RESP = 1'b1
    } lsu_state_e;

    function automatic logic op_is_store(input lsu_op_e op);
        return op[1];
    endfunction

    function automatic logic op_is_byte(input lsu_op_e op);
        return op[0];
    endfunction

endpackage

// File: rtl/lsu_agen.sv
module lsu_agen #(
    parameter int ADDR_W = 32,
    parameter int OFF_W  = 16,
    parameter int LANES  = 4
) (
    input  logic [ADDR_W-1:0]         base,
    input  logic [OFF_W-1:0]          offset,
    input  logic                      is_word,
    output logic [ADDR_W-1:0]         word_addr,
    output logic [$clog2(LANES)-1:0]  lane_sel,
    output logic                      misalign
);
    localparam int SEL_W = $clog2(LANES);

    logic [ADDR_W-1:0] byte_addr;

    always_comb begin
        byte_addr = base + {{(ADDR_W-OFF_W){offset[OFF_W-1]}}, offset};
        word_addr = {byte_addr[ADDR_W-1:SEL_W], {SEL_W{1'b0}}};
        lane_sel  = byte_addr[SEL_W-1:0];
        misalign  = is_word && (lane_sel != '0);
    end
endmodule

// File: rtl/lsu_store_lane.sv
module lsu_store_lane #(
    parameter int LANES = 4
) (
    input  logic                      enable,
    input  logic                      is_byte,
    input  logic [$clog2(LANES)-1:0]  lane_sel,
    input  logic [8*LANES-1:0]        src,
    output logic [LANES-1:0]          wen,
    output logic [8*LANES-1:0]        wdata
);
    localparam int SEL_W = $clog2(LANES);

    for (genvar g = 0; g < LANES; g++) begin : g_lane
        // lane g holds byte offset LANES-1-g (big-endian numbering)
        assign wdata[8*g +: 8] = is_byte ? src[7:0] : src[8*g +: 8];
        assign wen[g] = enable && (!is_byte || (lane_sel == SEL_W'(LANES-1-g)));
    end
endmodule

// File: rtl/lsu_load_extract.sv
module lsu_load_extract #(
    parameter int LANES = 4
) (
    input  logic [8*LANES-1:0]        rdata,
    input  logic                      is_byte,
    input  logic [$clog2(LANES)-1:0]  lane_sel,
    output logic [8*LANES-1:0]        data
);
    localparam int SEL_W  = $clog2(LANES);
    localparam int DATA_W = 8 * LANES;

    logic [7:0] picked;

    always_comb begin
        picked = '0;
        for (int i = 0; i < LANES; i++) begin
            if (lane_sel == SEL_W'(i)) begin
                picked = rdata[8*(LANES-1-i) +: 8];
            end
        end
        data = is_byte ? {{(DATA_W-8){picked[7]}}, picked} : rdata;
    end
endmodule

// File: rtl/lsu_align.sv
module lsu_align
    import lsu_align_pkg::*;
#(
    parameter int ADDR_W = 32,
    parameter int OFF_W  = 16,
    parameter int LANES  = 4
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  req_valid,
    input  logic [1:0]            req_op,
    input  logic [ADDR_W-1:0]     req_base,
    input  logic [OFF_W-1:0]      req_offset,
    input  logic [8*LANES-1:0]    req_src,
    output logic [ADDR_W-1:0]     mem_addr,
    output logic                  mem_rd,
    output logic [LANES-1:0]      mem_wen,
    output logic [8*LANES-1:0]    mem_wdata,
    input  logic [8*LANES-1:0]    mem_rdata,
    output logic                  align_fault,
    output logic                  ld_valid,
    output logic [8*LANES-1:0]    ld_data
);
    localparam int SEL_W = $clog2(LANES);

    lsu_op_e          op;
    lsu_state_e       state_q, state_d;
    logic [SEL_W-1:0] lane_sel, lane_q;
    logic             byte_q;
    logic             misalign, is_store, is_byte, load_go, store_go;

    assign op       = lsu_op_e'(req_op);
    assign is_store = op_is_store(op);
    assign is_byte  = op_is_byte(op);

    lsu_agen #(.ADDR_W(ADDR_W), .OFF_W(OFF_W), .LANES(LANES)) u_agen (
        .base      (req_base),
        .offset    (req_offset),
        .is_word   (!is_byte),
        .word_addr (mem_addr),
        .lane_sel  (lane_sel),
        .misalign  (misalign)
    );

    assign align_fault = req_valid && misalign;
    assign load_go     = req_valid && !is_store && !misalign;
    assign store_go    = req_valid && is_store && !misalign;
    assign mem_rd      = load_go;

    lsu_store_lane #(.LANES(LANES)) u_store (
        .enable   (store_go),
        .is_byte  (is_byte),
        .lane_sel (lane_sel),
        .src      (req_src),
        .wen      (mem_wen),
        .wdata    (mem_wdata)
    );

    lsu_load_extract #(.LANES(LANES)) u_load (
        .rdata    (mem_rdata),
        .is_byte  (byte_q),
        .lane_sel (lane_q),
        .data     (ld_data)
    );

    // next state
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:      state_d = load_go ? ST_LOAD_RESP : ST_IDLE;
            ST_LOAD_RESP: state_d = load_go ? ST_LOAD_RESP : ST_IDLE;
            default:      state_d = ST_IDLE;
        endcase
    end

    // state register and captured request fields
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            lane_q  <= '0;
            byte_q  <= 1'b0;
        end else begin
            state_q <= state_d;
            if (load_go) begin
                lane_q <= lane_sel;
                byte_q <= is_byte;
            end
        end
    end

    // outputs
    always_comb begin
        ld_valid = 1'b0;
        unique case (state_q)
            ST_IDLE:      ld_valid = 1'b0;
            ST_LOAD_RESP: ld_valid = 1'b1;
            default:      ld_valid = 1'b0;
        endcase
    end
endmodule

// File: rtl/lsu_align_chk.sv
module lsu_align_chk #(
    parameter int ADDR_W = 32,
    parameter int OFF_W  = 16,
    parameter int LANES  = 4
) (
    input logic                clk,
    input logic                rst_n,
    input logic                req_valid,
    input logic [1:0]          req_op,
    input logic                mem_rd,
    input logic [LANES-1:0]    mem_wen,
    input logic                align_fault,
    input logic                ld_valid
);
    p_fault_blocks_r2: assert property (@(posedge clk) disable iff (!rst_n)
        align_fault |-> (mem_wen == '0 && !mem_rd));

    p_fault_word_only_r2: assert property (@(posedge clk) disable iff (!rst_n)
        align_fault |-> (req_valid && !req_op[0]));

    p_sw_all_lanes_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_op == 2'b10 && !align_fault) |-> (mem_wen == '1));

    p_sb_one_lane_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_op == 2'b11) |-> ($countones(mem_wen) == 1 && !align_fault));

    p_load_resp_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && !req_op[1] && !align_fault) |=> ld_valid);

    p_rd_wr_excl_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !(mem_rd && mem_wen != '0));

    p_idle_quiet_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !req_valid |-> (!mem_rd && mem_wen == '0 && !align_fault));

    p_resp_follows_rd_r10: assert property (@(posedge clk) disable iff (!rst_n)
        ld_valid |-> $past(mem_rd));
endmodule

bind lsu_align lsu_align_chk #(.ADDR_W(ADDR_W), .OFF_W(OFF_W), .LANES(LANES)) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .req_valid   (req_valid),
    .req_op      (req_op),
    .mem_rd      (mem_rd),
    .mem_wen     (mem_wen),
    .align_fault (align_fault),
    .ld_valid    (ld_valid)
);

// File: tb/lsu_align_bench.sv
module lsu_align_bench;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0;
    logic [1:0]  req_op = '0;
    logic [31:0] req_base = '0;
    logic [15:0] req_offset = '0;
    logic [31:0] req_src = '0;
    logic [31:0] mem_addr, mem_wdata, ld_data;
    logic [31:0] mem_rdata = '0;
    logic [3:0]  mem_wen;
    logic        mem_rd, align_fault, ld_valid;

    int checks = 0;
    int errors = 0;
    int cycles = 0;

    logic [31:0] model_mem [16];
    logic [31:0] ref_mem   [16];
    logic        exp_v = 1'b0;
    logic [31:0] exp_d = '0;
    string       exp_tag = "";

    always #(CLK_PERIOD/2) clk = ~clk;

    lsu_align u_lsu_align (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_op(req_op),
        .req_base(req_base), .req_offset(req_offset), .req_src(req_src),
        .mem_addr(mem_addr), .mem_rd(mem_rd), .mem_wen(mem_wen),
        .mem_wdata(mem_wdata), .mem_rdata(mem_rdata), .align_fault(align_fault),
        .ld_valid(ld_valid), .ld_data(ld_data)
    );

    // memory model driven by the unit's outputs
    always @(posedge clk) begin
        if (mem_rd) mem_rdata <= model_mem[mem_addr[5:2]];
        for (int l = 0; l < 4; l++)
            if (mem_wen[l]) model_mem[mem_addr[5:2]][8*l +: 8] <= mem_wdata[8*l +: 8];
    end

    task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    function automatic logic [31:0] f_sext16(input logic [15:0] v);
        return {{16{v[15]}}, v};
    endfunction

    function automatic logic [7:0] f_byte(input logic [31:0] w, input int k);
        return w[31-8*k -: 8];
    endfunction

    // one cycle: check previous load result, then drive and check a new request
    task automatic step(input bit v, input logic [1:0] op, input logic [31:0] ea,
                        input logic [15:0] off, input logic [31:0] src);
        int k, idx;
        logic [7:0] b;
        @(negedge clk);
        chk(ld_valid == exp_v, "R10 ld_valid", {31'd0, ld_valid}, {31'd0, exp_v});
        if (exp_v) chk(ld_data == exp_d, exp_tag, ld_data, exp_d);
        req_valid  = v;
        req_op     = op;
        req_offset = off;
        req_base   = ea - f_sext16(off);
        req_src    = src;
        #1;
        k = int'(ea[1:0]);
        idx = int'(ea[5:2]);
        exp_v = 1'b0;
        if (!v) begin
            chk(!mem_rd && mem_wen == 4'd0 && !align_fault, "R9 quiet", {mem_rd, mem_wen, align_fault}, 0);
        end else begin
            chk(mem_addr == {ea[31:2], 2'b00}, "R1 mem_addr", mem_addr, {ea[31:2], 2'b00});
            if (!op[0] && k != 0) begin
                chk(align_fault && !mem_rd && mem_wen == 4'd0, "R2 fault",
                    {align_fault, mem_rd, mem_wen}, 6'b100000);
            end else begin
                chk(!align_fault, "R2 no fault", {31'd0, align_fault}, 0);
                unique case (op)
                    2'b00: begin
                        chk(mem_rd && mem_wen == 0, "R6 rd", {mem_rd, mem_wen}, 5'b10000);
                        exp_v = 1'b1; exp_d = ref_mem[idx]; exp_tag = "R6 word load";
                    end
                    2'b01: begin
                        chk(mem_rd && mem_wen == 0, "R7 rd", {mem_rd, mem_wen}, 5'b10000);
                        b = f_byte(ref_mem[idx], k);
                        exp_v = 1'b1; exp_d = {{24{b[7]}}, b}; exp_tag = "R7 R8 byte load";
                    end
                    2'b10: begin
                        chk(mem_wen == 4'hF && mem_wdata == src && !mem_rd, "R3 word store",
                            {mem_wen, mem_wdata[27:0]}, {4'hF, src[27:0]});
                        ref_mem[idx] = src;
                    end
                    default: begin
                        chk(mem_wen == (4'b1000 >> k) && mem_wdata == {4{src[7:0]}}, "R4 byte store",
                            {mem_wen, mem_wdata[27:0]}, {4'b1000 >> k, {4{src[7:0]}}[27:0]});
                        ref_mem[idx][31-8*k -: 8] = src[7:0];
                    end
                endcase
            end
        end
    endtask

    initial begin : watchdog
        forever begin
            @(posedge clk);
            cycles++;
            if (cycles > 100000) begin
                errors++;
                checks++;
                $display("FAIL watchdog expired");
                $display("CHECKS %0d ERRORS %0d", checks, errors);
                $finish;
            end
        end
    end

    initial begin : main
        logic [31:0] ea;
        logic [1:0]  op;
        void'($urandom(32'h5EED_1234));
        for (int i = 0; i < 16; i++) begin
            model_mem[i] = 32'h80FF_7F01 ^ (i * 32'h0101_1111);
            ref_mem[i]   = 32'h80FF_7F01 ^ (i * 32'h0101_1111);
        end
        repeat (3) @(posedge clk);
        @(negedge clk);
        chk(!ld_valid && !mem_rd && mem_wen == 0 && !align_fault, "R9 reset",
            {ld_valid, mem_rd, mem_wen, align_fault}, 0);
        rst_n = 1'b1;
        step(0, 2'b00, 0, 0, 0);

        // R5: byte stores into one word, then read back whole word
        step(1, 2'b10, 32'h10, 16'h0004, 32'h1122_3344);
        step(1, 2'b11, 32'h11, 16'hFFFF, 32'h0000_00AB);
        step(1, 2'b11, 32'h13, 16'h0003, 32'h0000_00CD);
        step(1, 2'b00, 32'h10, 16'h0000, 0);          // R5 expects 11AB33CD
        // R8 back-to-back byte loads, negative lane included
        step(1, 2'b01, 32'h10, 16'h0010, 0);
        step(1, 2'b01, 32'h11, 16'h8000, 0);
        step(1, 2'b01, 32'h12, 16'h7FFF, 0);
        step(1, 2'b01, 32'h13, 16'h0001, 0);
        // R2 misaligned word store must not change memory
        step(1, 2'b10, 32'h21, 16'h0001, 32'hDEAD_BEEF);
        step(1, 2'b10, 32'h22, 16'h0000, 32'hDEAD_BEEF);
        step(1, 2'b00, 32'h23, 16'hFFF0, 0);
        step(1, 2'b00, 32'h20, 16'h0000, 0);
        // R1 wrap: negative offset across zero
        step(1, 2'b00, 32'hFFFF_FFFC, 16'hFFFC, 0);
        step(1, 2'b11, 32'hFFFF_FFFF, 16'hFFFF, 32'h0000_0080);
        step(1, 2'b01, 32'h3F, 16'h0000, 0);          // R7 sign extend of 0x80
        step(0, 2'b00, 0, 0, 0);

        for (int n = 0; n < 400; n++) begin
            op = 2'($urandom_range(0, 3));
            ea = 32'($urandom_range(0, 63));
            if (!op[0] && ($urandom_range(0, 3) != 0)) ea[1:0] = 2'b00;
            step($urandom_range(0, 7) != 0, op, ea, 16'($urandom), $urandom);
        end
        step(0, 2'b00, 0, 0, 0);
        step(0, 2'b00, 0, 0, 0);

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule